// File: doc/BRIEF.md
# Dual Warp Issue Scheduler

This block is the issue stage of one compute cluster. It is given a table of warp states: for each warp, whether the slot holds a live warp, whether that warp's next instruction is ready, and which execution group that instruction needs. Each clock, two independent schedulers each choose at most one warp and send its instruction to one of three execution groups. The groups are a 16-lane arithmetic group, a 16-lane load/store group and a 4-lane special-function group.

A warp carries 32 threads, so one instruction keeps a narrow group busy for several clocks. The block tracks that occupancy itself, and it drives a busy flag per group. A per-group hold input lets a stalled datapath refuse new work. The schedulers own disjoint halves of the warp table, so they never contend for the same warp. They can contend for the same group. A parity-alternating tie-break settles that contention, and the losing scheduler falls back to another of its warps that targets a different group.

Top module: `dual_warp_issue`

## Requirements
- R1: While reset is asserted, and in the first clock after it, no issue record is valid and every group busy flag is low.
- R2: Slot 0 of the issue record only carries even warp IDs and slot 1 only carries odd warp IDs.
- R3: A warp is issued only if its valid and ready bits are set, its target group is not busy and not held, and its group code is 0 (arithmetic), 1 (load/store) or 2 (special-function). Code 3 never issues.
- R4: Among its eligible warps, each scheduler takes the first one found when searching its own warps in rising ID order, starting at the warp after the one it last issued and wrapping around.
- R5: The two slots of one issue record never carry the same group.
- R6: On a group conflict, scheduler 0 takes precedence in even clocks and scheduler 1 in odd clocks. The first clock after reset counts as even. The other scheduler then picks among its eligible warps that target a different group.
- R7: An arithmetic or load/store issue occupies its group for 2 clocks. The group's busy flag is high for exactly the 1 clock in which the record appears, and the group can be issued to again in the next clock.
- R8: A special-function issue occupies its group for 8 clocks. The busy flag is high for 7 clocks, starting with the clock in which the record appears.
- R9: A warp that has issued is not issued again until the group it issued to has finished that instruction, whatever its ready bit says.
- R10: While a group's hold bit is high, nothing is issued to that group. A hold does not extend a running occupancy.
- R11: The issue record and the busy flags are registered. A decision made from the inputs of one clock appears on the outputs after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_valid | input | NUM_WARPS | Slot holds a live warp |
| warp_ready | input | NUM_WARPS | Warp's next instruction may issue |
| warp_group | input | 2*NUM_WARPS | Per-warp group code, 2 bits per warp at bits [2w+1:2w] |
| grp_hold | input | 3 | Per-group stall from the datapath, bit = group code |
| iss_valid | output | 2 | Record valid, bit s for scheduler s |
| iss_warp | output | 2*WW | Warp ID for slot s at bits [s*WW +: WW] |
| iss_group | output | 4 | Group code for slot s at bits [2s+1:2s] |
| grp_busy | output | 3 | Group still executing an earlier instruction |

## Verification
The bench targets the points where a plausible design goes wrong. Two warps want one group, and the tie-break parity is off by a clock or fixed to one scheduler, so the wrong slot wins or the loser stalls instead of falling back to another group. The occupancy window is off by one, so the special-function group takes its next warp a clock early or late, or the arithmetic group sits idle every other slot. The round-robin pointer restarts at the lowest warp, so higher warps starve. A held group still takes work, or a group code of 3 slips through. A cycle-accurate model in the bench runs the same inputs, and both directed patterns and long random runs are compared against it on every clock.

// File: rtl/dwi_pkg.sv
package dwi_pkg;

    typedef enum logic [1:0] {
        GRP_ALU  = 2'd0,
        GRP_LSU  = 2'd1,
        GRP_SFU  = 2'd2,
        GRP_NONE = 2'd3
    } grp_e;

    localparam int NUM_GRP = 3;

endpackage

// File: rtl/dwi_occupancy.sv
module dwi_occupancy #(
    parameter int OCC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic busy_next_o
);
    localparam int CW = (OCC > 1) ? $clog2(OCC) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } occ_st_t;

    occ_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.cnt = CW'(OCC - 1);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
        busy_next_o = (st_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.cnt != '0);

    // R7 / R8: a group never restarts while still executing
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    // R8: once started, the group stays busy until the count drains
    a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && st_q.cnt != CW'(1)) |=> busy_o);

endmodule

// File: rtl/dwi_picker.sv
module dwi_picker #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]  cand_i,
    input  logic [PW-1:0] ptr_i,
    output logic          found_o,
    output logic [PW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (cand_i[(int'(ptr_i) + k) % N]) begin
                found_o = 1'b1;
                idx_o   = PW'((int'(ptr_i) + k) % N);
            end
        end
    end
endmodule

// File: rtl/dual_warp_issue.sv
module dual_warp_issue #(
    parameter int NUM_WARPS = 8,
    parameter int WARP_SIZE = 32,
    parameter int ALU_LANES = 16,
    parameter int LSU_LANES = 16,
    parameter int SFU_LANES = 4,
    localparam int WW = $clog2(NUM_WARPS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_WARPS-1:0]   warp_valid,
    input  logic [NUM_WARPS-1:0]   warp_ready,
    input  logic [2*NUM_WARPS-1:0] warp_group,
    input  logic [2:0]             grp_hold,
    output logic [1:0]             iss_valid,
    output logic [2*WW-1:0]        iss_warp,
    output logic [3:0]             iss_group,
    output logic [2:0]             grp_busy
);
    import dwi_pkg::*;

    localparam int HALF = NUM_WARPS / 2;
    localparam int PW   = WW - 1;

    function automatic int occ_of(int g);
        case (g)
            0:       return WARP_SIZE / ALU_LANES;
            1:       return WARP_SIZE / LSU_LANES;
            default: return WARP_SIZE / SFU_LANES;
        endcase
    endfunction

    typedef struct packed {
        logic [1:0]             vld;
        logic [2*WW-1:0]        warp;
        logic [3:0]             grp;
        logic [PW-1:0]          ptr0;
        logic [PW-1:0]          ptr1;
        logic                   par;
        logic [NUM_WARPS-1:0]   pend;
        logic [2*NUM_WARPS-1:0] pgrp;
    } st_t;

    st_t st_d, st_q;

    logic [1:0]           wg [NUM_WARPS];
    logic [NUM_WARPS-1:0] elig;
    logic [3:0]           free4;
    logic [HALF-1:0]      cand0, cand1, cand_a, cand_b;
    logic [PW-1:0]        ptr_a, ptr_b, idx_a, idx_b, i0, i1;
    logic                 found_a, found_b, f0, f1, sa;
    logic [1:0]           grp_a, g0, g1;
    logic [2:0]           start, busy, busy_nx;
    logic [3:0]           busy_nx4;

    // ---------------- group occupancy ----------------
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_occ
        dwi_occupancy #(.OCC(occ_of(g))) u_occ (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_i    (start[g]),
            .busy_o     (busy[g]),
            .busy_next_o(busy_nx[g])
        );
    end
    assign busy_nx4 = {1'b0, busy_nx};

    // ---------------- eligibility ----------------
    always_comb begin
        free4 = {1'b0, ~busy & ~grp_hold};
        for (int w = 0; w < NUM_WARPS; w++) begin
            wg[w]   = warp_group[2*w +: 2];
            elig[w] = warp_valid[w] && warp_ready[w] && !st_q.pend[w] && free4[wg[w]];
        end
        for (int s = 0; s < HALF; s++) begin
            cand0[s] = elig[2*s];
            cand1[s] = elig[2*s+1];
        end
        sa     = st_q.par;
        cand_a = sa ? cand1 : cand0;
        ptr_a  = sa ? st_q.ptr1 : st_q.ptr0;
        ptr_b  = sa ? st_q.ptr0 : st_q.ptr1;
    end

    // precedence scheduler picks first
    dwi_picker #(.N(HALF), .PW(PW)) u_pick_a (
        .cand_i (cand_a),
        .ptr_i  (ptr_a),
        .found_o(found_a),
        .idx_o  (idx_a)
    );

    // the other scheduler avoids the group just taken
    always_comb begin
        grp_a = wg[{idx_a, sa}];
        for (int s = 0; s < HALF; s++) begin
            cand_b[s] = (sa ? cand0[s] : cand1[s]) &&
                        !(found_a && wg[2*s + (sa ? 0 : 1)] == grp_a);
        end
    end

    dwi_picker #(.N(HALF), .PW(PW)) u_pick_b (
        .cand_i (cand_b),
        .ptr_i  (ptr_b),
        .found_o(found_b),
        .idx_o  (idx_b)
    );

    // map roles back to scheduler slots
    always_comb begin
        f0 = sa ? found_b : found_a;
        i0 = sa ? idx_b   : idx_a;
        f1 = sa ? found_a : found_b;
        i1 = sa ? idx_a   : idx_b;
        g0 = wg[{i0, 1'b0}];
        g1 = wg[{i1, 1'b1}];
        for (int g = 0; g < NUM_GRP; g++) begin
            start[g] = (f0 && g0 == 2'(g)) || (f1 && g1 == 2'(g));
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d      = st_q;
        st_d.par  = ~st_q.par;
        st_d.vld  = {f1, f0};
        st_d.warp = {(f1 ? {i1, 1'b1} : WW'(0)), (f0 ? {i0, 1'b0} : WW'(0))};
        st_d.grp  = {(f1 ? g1 : 2'b00), (f0 ? g0 : 2'b00)};
        if (f0) st_d.ptr0 = i0 + PW'(1);
        if (f1) st_d.ptr1 = i1 + PW'(1);
        for (int w = 0; w < NUM_WARPS; w++) begin
            st_d.pend[w] = st_q.pend[w] && busy_nx4[st_q.pgrp[2*w +: 2]];
            if (f0 && WW'(w) == {i0, 1'b0}) begin
                st_d.pend[w]       = busy_nx4[g0];
                st_d.pgrp[2*w +: 2] = g0;
            end
            if (f1 && WW'(w) == {i1, 1'b1}) begin
                st_d.pend[w]       = busy_nx4[g1];
                st_d.pgrp[2*w +: 2] = g1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iss_valid = st_q.vld;
    assign iss_warp  = st_q.warp;
    assign iss_group = st_q.grp;
    assign grp_busy  = busy;

    // ---------------- assertions ----------------
    logic rec_alu, rec_sfu;
    assign rec_alu = (iss_valid[0] && iss_group[1:0] == GRP_ALU) ||
                     (iss_valid[1] && iss_group[3:2] == GRP_ALU);
    assign rec_sfu = (iss_valid[0] && iss_group[1:0] == GRP_SFU) ||
                     (iss_valid[1] && iss_group[3:2] == GRP_SFU);

    a_r5_distinct_groups: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid == 2'b11) |-> (iss_group[1:0] != iss_group[3:2]));

    a_r2_parity_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[0] |-> !iss_warp[0]);

    a_r2_parity_slot1: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[1] |-> iss_warp[WW]);

    a_r7_alu_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rec_alu |=> !rec_alu);

    a_r8_sfu_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rec_sfu |-> grp_busy[GRP_SFU]);

    a_r3_no_none_group: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid[0] |-> iss_group[1:0] != GRP_NONE) and
        (iss_valid[1] |-> iss_group[3:2] != GRP_NONE));

    a_r10_sfu_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rec_sfu |-> $past(!grp_hold[GRP_SFU]));

    a_r10_alu_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rec_alu |-> $past(!grp_hold[GRP_ALU]));

endmodule

// File: tb/dual_warp_issue_bench.sv
module dual_warp_issue_bench;

    localparam int NW   = 8;
    localparam int WW   = 3;
    localparam int HALF = NW / 2;
    localparam int OCC_ALU = 2;
    localparam int OCC_LSU = 2;
    localparam int OCC_SFU = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NW-1:0]   warp_valid = '0;
    logic [NW-1:0]   warp_ready = '0;
    logic [2*NW-1:0] warp_group = '0;
    logic [2:0]      grp_hold = '0;
    logic [1:0]      iss_valid;
    logic [2*WW-1:0] iss_warp;
    logic [3:0]      iss_group;
    logic [2:0]      grp_busy;

    always #5 clk = ~clk;

    dual_warp_issue u_dual_warp_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .warp_valid(warp_valid),
        .warp_ready(warp_ready),
        .warp_group(warp_group),
        .grp_hold  (grp_hold),
        .iss_valid (iss_valid),
        .iss_warp  (iss_warp),
        .iss_group (iss_group),
        .grp_busy  (grp_busy)
    );

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    // behavioural reference state
    int mcnt [3];
    int mptr [2];
    int mpar;
    bit mpend [NW];
    int mpgrp [NW];
    bit melig [NW];
    bit evld  [2];
    int ewarp [2];
    int egrp  [2];
    int ebusy;

    function automatic int occ(int g);
        return (g == 0) ? OCC_ALU : (g == 1) ? OCC_LSU : OCC_SFU;
    endfunction

    function automatic int grp_in(int w);
        return int'(warp_group[2*w +: 2]);
    endfunction

    function automatic int mpick(int s, int excl);
        for (int k = 0; k < HALF; k++) begin
            int slot;
            int w;
            slot = (mptr[s] + k) % HALF;
            w    = 2 * slot + s;
            if (melig[w] && grp_in(w) != excl) return slot;
        end
        return -1;
    endfunction

    task automatic model_reset();
        for (int g = 0; g < 3; g++) mcnt[g] = 0;
        mptr[0] = 0; mptr[1] = 0; mpar = 0;
        for (int w = 0; w < NW; w++) begin mpend[w] = 1'b0; mpgrp[w] = 0; end
        evld[0] = 0; evld[1] = 0; ewarp[0] = 0; ewarp[1] = 0;
        egrp[0] = 0; egrp[1] = 0; ebusy = 0;
    endtask

    task automatic model_step();
        int a, b, pa, pb, ga;
        int slot [2];
        for (int w = 0; w < NW; w++) begin
            int g;
            g = grp_in(w);
            melig[w] = warp_valid[w] && warp_ready[w] && !mpend[w] && g < 3 &&
                       mcnt[g] == 0 && !grp_hold[g];
        end
        a  = mpar; b = 1 - mpar;
        pa = mpick(a, -1);
        ga = (pa >= 0) ? grp_in(2 * pa + a) : -1;
        pb = mpick(b, ga);
        slot[a] = pa; slot[b] = pb;
        for (int g = 0; g < 3; g++) if (mcnt[g] > 0) mcnt[g]--;
        for (int s = 0; s < 2; s++) begin
            evld[s] = (slot[s] >= 0);
            ewarp[s] = evld[s] ? 2 * slot[s] + s : 0;
            egrp[s]  = evld[s] ? grp_in(ewarp[s]) : 0;
            if (evld[s]) begin
                mcnt[egrp[s]] = occ(egrp[s]) - 1;
                mptr[s] = (slot[s] + 1) % HALF;
            end
        end
        for (int w = 0; w < NW; w++) mpend[w] = mpend[w] && mcnt[mpgrp[w]] != 0;
        for (int s = 0; s < 2; s++) if (evld[s]) begin
            mpend[ewarp[s]] = mcnt[egrp[s]] != 0;
            mpgrp[ewarp[s]] = egrp[s];
        end
        mpar = 1 - mpar;
        ebusy = 0;
        for (int g = 0; g < 3; g++) if (mcnt[g] != 0) ebusy |= (1 << g);
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // inputs set before the call are sampled at the next rising edge
    task automatic step(string tag);
        model_step();
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            chk(iss_valid[s] == evld[s], {tag, " valid (R11)"}, int'(iss_valid[s]), int'(evld[s]));
            if (evld[s] && iss_valid[s]) begin
                chk(int'(iss_warp[s*WW +: WW]) == ewarp[s], {tag, " warp (R4)"},
                    int'(iss_warp[s*WW +: WW]), ewarp[s]);
                chk(int'(iss_group[2*s +: 2]) == egrp[s], {tag, " group (R6)"},
                    int'(iss_group[2*s +: 2]), egrp[s]);
            end
        end
        chk(int'(grp_busy) == ebusy, {tag, " busy (R7 R8)"}, int'(grp_busy), ebusy);
        if (iss_valid == 2'b11)
            chk(iss_group[1:0] != iss_group[3:2], "R5 distinct groups",
                int'(iss_group[3:2]), int'(iss_group[1:0]));
        if (iss_valid[0])
            chk(!iss_warp[0], "R2 slot0 even", int'(iss_warp[WW-1:0]), 0);
        if (iss_valid[1])
            chk(iss_warp[WW], "R2 slot1 odd", int'(iss_warp[2*WW-1:WW]), 1);
    endtask

    task automatic clear_in();
        warp_valid = '0; warp_ready = '0; warp_group = '0; grp_hold = '0;
    endtask

    task automatic set_warp(int w, int g);
        warp_valid[w] = 1'b1;
        warp_ready[w] = 1'b1;
        warp_group[2*w +: 2] = 2'(g);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clear_in();
        model_reset();
        repeat (2) begin
            @(negedge clk);
            chk(iss_valid == 2'b00, "R1 reset valid", int'(iss_valid), 0);
            chk(grp_busy == 3'b000, "R1 reset busy", int'(grp_busy), 0);
        end
        rst_n = 1'b1;
    endtask

    initial begin
        int sfu_cnt;
        do_reset();
        // first clock after reset: nothing ready yet
        step("R1 first clock");

        // R7: one arithmetic warp, issue every other clock
        set_warp(0, 0);
        repeat (10) step("R7 R3 single alu");

        // R8 R9: two special-function warps on scheduler 0
        clear_in();
        set_warp(2, 2); set_warp(4, 2);
        sfu_cnt = 0;
        repeat (24) begin
            step("R8 R9 sfu");
            if (grp_busy[2]) sfu_cnt++;
        end
        // three SFU issues in 24 clocks (t=0,8,16), each 7 busy clocks
        chk(sfu_cnt == 21, "R8 sfu busy clocks", sfu_cnt, 21);

        // R6: both schedulers want arithmetic, then loser falls back to load/store
        do_reset();
        set_warp(0, 0); set_warp(1, 0);
        repeat (8) step("R6 alu conflict");
        set_warp(3, 1);
        repeat (8) step("R6 fallback lsu");

        // R10: held arithmetic group takes nothing
        clear_in();
        set_warp(0, 0); set_warp(5, 0);
        grp_hold = 3'b001;
        repeat (6) step("R10 hold alu");
        grp_hold = 3'b000;
        repeat (4) step("R10 release");

        // R4: round-robin across all even warps
        clear_in();
        for (int w = 0; w < NW; w += 2) set_warp(w, 0);
        repeat (12) step("R4 round robin");

        // R3: group code 3 never issues
        clear_in();
        set_warp(2, 3); set_warp(3, 3);
        repeat (4) step("R3 none group");

        // random traffic across every rule
        do_reset();
        for (int c = 0; c < 3000; c++) begin
            for (int w = 0; w < NW; w++) begin
                warp_valid[w] = ($urandom % 8) != 0;
                warp_ready[w] = ($urandom % 2) != 0;
                warp_group[2*w +: 2] = 2'($urandom % 4);
            end
            for (int g = 0; g < 3; g++) grp_hold[g] = ($urandom % 8) == 0;
            step("R2 R3 R4 R5 R6 R9 R10 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog act=0 exp=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule